// File: doc/BRIEF.md
# Banked DRAM Access and Refresh Sequencer

This block drives a 48 KiB byte-wide memory. The memory is built as three banks of 16K-by-1 dynamic RAM chips. The block watches the CPU address bus, the read and write strobes, an opcode-fetch marker and the CPU's refresh strobe. From these it makes a 7-bit multiplexed chip address, one active-low row strobe per bank, a shared active-low column strobe and the two data buffer enables.

An access is a fixed chain of steps. First the row strobe of the decoded bank falls while the low address half is on the chip address pins. The block then switches the address pins to the high half, and then the column strobe falls. Two parameters set the clock delays between these steps.

A refresh needs no counter inside the block. The CPU puts its own 7-bit row count on the low address lines and raises its refresh strobe. The block then lowers the row strobes of all three banks together, with the column strobe held high. A refresh that arrives during an access is remembered and run once the access has ended.

Top module: `dram_bank_seq`

## Requirements
- R1: In the row phase `dram_addr` carries `cpu_addr[6:0]`. In the column and CAS phases it carries `cpu_addr[13:7]`. `row_drv_en` is high and `col_drv_en` is low only in the row phase, and the reverse holds in the column and CAS phases.
- R2: Call E0 the clock edge that first samples a read, write or fetch strobe. The selected `ras_n` bit goes low at edge E0+1. The column switch happens RAS2COL edges later, and `cas_n` goes low COL2CAS edges after that. CAS is never low unless one bank's RAS is low and the column address is selected.
- R3: `cpu_addr[15:14]` picks the bank: value 0 drives `ras_n[0]`, value 1 drives `ras_n[1]` and value 2 drives `ras_n[2]`. During an access only that one bit is low.
- R4: Addresses 0xC000 and above start no cycle. All `ras_n` bits and `cas_n` stay high, and both buffer enables stay low.
- R5: A read, or a fetch with no write, raises `rdbuf_oe` only while `cas_n` is low. A write raises `wrbuf_en` from the row phase through the CAS phase and keeps `rdbuf_oe` low.
- R6: A refresh drives all three `ras_n` bits low with `cas_n` high. `dram_addr` carries `cpu_addr[6:0]` as sampled on the edge that first saw the refresh strobe.
- R7: The refresh strobe passes through one register, so the refresh RAS appears on the second clock edge after the strobe is driven. The refresh lasts at least RFSH_CYC clocks, and longer while the strobe stays high.
- R8: Every rising edge of the refresh strobe produces exactly one refresh cycle. This includes a strobe that arrives during an access, which is run after the access and its precharge.
- R9: On the edge after a CPU strobe is seen low, all RAS and CAS lines go high and the address returns to row mode. All RAS lines then stay high for at least PRE_CYC clocks before the next cycle.
- R10: `rdbuf_oe` and `wrbuf_en` are never high together.
- R11: While reset is high and on the first edge after it, all strobes are high, both enables are low and the row driver is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 16 | CPU address bus; carries the refresh row in bits 6:0 during refresh |
| mem_rd | input | 1 | Memory read strobe, active high |
| mem_wr | input | 1 | Memory write strobe, active high |
| opfetch | input | 1 | Opcode-fetch marker, active high; counts as a read |
| refresh | input | 1 | CPU refresh strobe, active high |
| dram_addr | output | 7 | Multiplexed chip address |
| ras_n | output | 3 | Per-bank row strobe, active low |
| cas_n | output | 1 | Shared column strobe, active low |
| row_drv_en | output | 1 | Row-half address driver enable |
| col_drv_en | output | 1 | Column-half address driver enable |
| rdbuf_oe | output | 1 | Drives memory data onto the CPU input data bus |
| wrbuf_en | output | 1 | Routes CPU output data to the chip data inputs |

## Verification
The assertions check several rules on every cycle. CAS falls only with exactly one bank's RAS low and the column driver selected. A refresh never carries CAS. The two buffer enables exclude each other. Any fall of RAS activity is followed by a precharge clock. CAS is reached only through the column step. A refresh edge always leaves a pending request.

Some behaviour only the bench scenarios can show. These are the exact edge on which each strobe moves, the row and column halves seen on the pins, the bank decode across the address space, and the silence above 0xC000. The bench also shows the refresh row value for all 128 rows, and that a refresh raised in the middle of an access is run once that access has closed.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

    localparam int ROW_W     = 7;
    localparam int CHIP_AW   = 2 * ROW_W;
    localparam int ADDR_W    = 16;
    localparam int NUM_BANKS = 3;
    localparam int BANK_W    = ADDR_W - CHIP_AW;
    localparam logic [ADDR_W:0] MEM_TOP = (ADDR_W + 1)'(NUM_BANKS) << CHIP_AW;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_COL,
        ST_CAS,
        ST_RFSH,
        ST_PRE
    } seq_state_e;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [ROW_W-1:0]  col;
        logic              is_wr;
    } access_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              rd;
        logic              wr;
        logic              fetch;
        logic              rf;
    } bus_sample_t;

    function automatic logic in_window(input logic [ADDR_W-1:0] a);
        return {1'b0, a} < MEM_TOP;
    endfunction

    function automatic logic [BANK_W-1:0] bank_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:CHIP_AW];
    endfunction

    function automatic logic [ROW_W-1:0] row_of(input logic [ADDR_W-1:0] a);
        return a[ROW_W-1:0];
    endfunction

    function automatic logic [ROW_W-1:0] col_of(input logic [ADDR_W-1:0] a);
        return a[CHIP_AW-1:ROW_W];
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dseq_input_sync.sv
module dseq_input_sync
    import dram_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic                mem_rd,
    input  logic                mem_wr,
    input  logic                opfetch,
    input  logic                refresh,
    input  logic                rf_ack,
    output bus_sample_t         smp,
    output logic                rf_pend,
    output logic [ROW_W-1:0]    rf_row
);

    logic rf_rise;
    assign rf_rise = refresh && !smp.rf;

    always_ff @(posedge clk) begin
        if (rst) begin
            smp     <= '0;
            rf_pend <= 1'b0;
            rf_row  <= '0;
        end else begin
            smp.addr  <= cpu_addr;
            smp.rd    <= mem_rd;
            smp.wr    <= mem_wr;
            smp.fetch <= opfetch;
            smp.rf    <= refresh;
            if (rf_rise) begin
                rf_pend <= 1'b1;
                rf_row  <= row_of(cpu_addr);
            end else if (rf_ack) begin
                rf_pend <= 1'b0;
            end
        end
    end

    // Every refresh edge leaves a request behind it (R8)
    assert_rf_edge_kept_R8: assert property (@(posedge clk) disable iff (rst)
        (refresh && !smp.rf) |=> rf_pend);

endmodule

// File: rtl/dseq_fsm.sv
module dseq_fsm
    import dram_seq_pkg::*;
#(
    parameter int RAS2COL  = 2,
    parameter int COL2CAS  = 1,
    parameter int PRE_CYC  = 1,
    parameter int RFSH_CYC = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  bus_sample_t smp,
    input  logic        rf_pend,
    output seq_state_e  state,
    output access_t     acc,
    output logic        rf_ack
);

    localparam int MAX_WAIT = max_of(max_of(RAS2COL, COL2CAS), max_of(PRE_CYC, RFSH_CYC));
    localparam int CNT_W    = $clog2(MAX_WAIT + 1);
    localparam logic [CNT_W-1:0] LD_R2C = CNT_W'(RAS2COL - 1);
    localparam logic [CNT_W-1:0] LD_C2C = CNT_W'(COL2CAS - 1);
    localparam logic [CNT_W-1:0] LD_PRE = CNT_W'(PRE_CYC - 1);
    localparam logic [CNT_W-1:0] LD_RF  = CNT_W'(RFSH_CYC - 1);

    initial begin
        assert (RAS2COL >= 1 && COL2CAS >= 1 && PRE_CYC >= 1 && RFSH_CYC >= 1);
    end

    seq_state_e       st_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic             strobe;
    logic             start_acc;
    logic             cnt_done;

    assign strobe    = smp.rd || smp.wr || smp.fetch;
    assign start_acc = strobe && in_window(smp.addr);
    assign cnt_done  = (cnt == '0);
    assign rf_ack    = (state == ST_IDLE) && rf_pend;

    always_comb begin
        st_nx  = state;
        cnt_nx = cnt;
        unique case (state)
            ST_IDLE: begin
                if (rf_pend) begin
                    st_nx  = ST_RFSH;
                    cnt_nx = LD_RF;
                end else if (start_acc) begin
                    st_nx  = ST_ROW;
                    cnt_nx = LD_R2C;
                end
            end
            ST_ROW: begin
                if (!strobe) begin
                    st_nx  = ST_PRE;
                    cnt_nx = LD_PRE;
                end else if (cnt_done) begin
                    st_nx  = ST_COL;
                    cnt_nx = LD_C2C;
                end else begin
                    cnt_nx = cnt - 1'b1;
                end
            end
            ST_COL: begin
                if (!strobe) begin
                    st_nx  = ST_PRE;
                    cnt_nx = LD_PRE;
                end else if (cnt_done) begin
                    st_nx  = ST_CAS;
                end else begin
                    cnt_nx = cnt - 1'b1;
                end
            end
            ST_CAS: begin
                if (!strobe) begin
                    st_nx  = ST_PRE;
                    cnt_nx = LD_PRE;
                end
            end
            ST_RFSH: begin
                if (!cnt_done) begin
                    cnt_nx = cnt - 1'b1;
                end else if (!smp.rf) begin
                    st_nx  = ST_PRE;
                    cnt_nx = LD_PRE;
                end
            end
            ST_PRE: begin
                if (cnt_done) st_nx = ST_IDLE;
                else          cnt_nx = cnt - 1'b1;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            acc   <= '0;
        end else begin
            state <= st_nx;
            cnt   <= cnt_nx;
            if (state == ST_IDLE && !rf_pend && start_acc) begin
                acc.bank  <= bank_of(smp.addr);
                acc.row   <= row_of(smp.addr);
                acc.col   <= col_of(smp.addr);
                acc.is_wr <= smp.wr;
            end
        end
    end

    // An access entered from idle always carries a bank inside the window (R4)
    assert_bank_in_window_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ROW && $past(state) == ST_IDLE) |-> (int'(acc.bank) < NUM_BANKS));

    // CAS phase is reached only through the column phase (R2)
    assert_cas_via_col_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CAS && $past(state) != ST_CAS) |-> $past(state) == ST_COL);

    // Precharge always ends in idle (R9)
    assert_pre_exit_idle_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == ST_PRE && state != ST_PRE) |-> state == ST_IDLE);

endmodule

// File: rtl/dseq_out_drv.sv
module dseq_out_drv
    import dram_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  seq_state_e       state,
    input  access_t          acc,
    input  logic [ROW_W-1:0] idle_row,
    input  logic [ROW_W-1:0] rf_row,
    output logic [ROW_W-1:0] dram_addr,
    output logic [NUM_BANKS-1:0] ras_n,
    output logic             cas_n,
    output logic             row_drv_en,
    output logic             col_drv_en,
    output logic             rdbuf_oe,
    output logic             wrbuf_en
);

    logic in_access;
    logic in_rfsh;

    assign in_access = (state == ST_ROW) || (state == ST_COL) || (state == ST_CAS);
    assign in_rfsh   = (state == ST_RFSH);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_ras
        assign ras_n[b] = !(in_rfsh || (in_access && acc.bank == BANK_W'(b)));
    end

    assign cas_n      = (state != ST_CAS);
    assign col_drv_en = (state == ST_COL) || (state == ST_CAS);
    assign row_drv_en = !col_drv_en;
    assign rdbuf_oe   = (state == ST_CAS) && !acc.is_wr;
    assign wrbuf_en   = in_access && acc.is_wr;

    always_comb begin
        if (in_rfsh)              dram_addr = rf_row;
        else if (col_drv_en)      dram_addr = acc.col;
        else if (state == ST_ROW) dram_addr = acc.row;
        else                      dram_addr = idle_row;
    end

    // Column strobe only with a single bank open (R3)
    assert_single_bank_R3: assert property (@(posedge clk) disable iff (rst)
        !cas_n |-> $countones(~ras_n) == 1);

    // Column strobe only with the column half selected (R2)
    assert_cas_col_R2: assert property (@(posedge clk) disable iff (rst)
        !cas_n |-> (col_drv_en && !row_drv_en));

    // All banks open means refresh, which never carries CAS (R6)
    assert_rfsh_no_cas_R6: assert property (@(posedge clk) disable iff (rst)
        (ras_n == '0) |-> cas_n);

    // Read buffer only while the column strobe is low (R5)
    assert_rd_in_cas_R5: assert property (@(posedge clk) disable iff (rst)
        rdbuf_oe |-> !cas_n);

    // The two data paths exclude each other (R10)
    assert_buf_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(rdbuf_oe && wrbuf_en));

endmodule

// File: rtl/dram_bank_seq.sv
module dram_bank_seq
    import dram_seq_pkg::*;
#(
    parameter int RAS2COL  = 2,
    parameter int COL2CAS  = 1,
    parameter int PRE_CYC  = 1,
    parameter int RFSH_CYC = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [15:0]          cpu_addr,
    input  logic                 mem_rd,
    input  logic                 mem_wr,
    input  logic                 opfetch,
    input  logic                 refresh,
    output logic [6:0]           dram_addr,
    output logic [2:0]           ras_n,
    output logic                 cas_n,
    output logic                 row_drv_en,
    output logic                 col_drv_en,
    output logic                 rdbuf_oe,
    output logic                 wrbuf_en
);

    bus_sample_t      smp;
    logic             rf_pend;
    logic [ROW_W-1:0] rf_row;
    logic             rf_ack;
    seq_state_e       state;
    access_t          acc;
    logic             ras_any;

    dseq_input_sync u_sync (
        .clk      (clk),
        .rst      (rst),
        .cpu_addr (cpu_addr),
        .mem_rd   (mem_rd),
        .mem_wr   (mem_wr),
        .opfetch  (opfetch),
        .refresh  (refresh),
        .rf_ack   (rf_ack),
        .smp      (smp),
        .rf_pend  (rf_pend),
        .rf_row   (rf_row)
    );

    dseq_fsm #(
        .RAS2COL  (RAS2COL),
        .COL2CAS  (COL2CAS),
        .PRE_CYC  (PRE_CYC),
        .RFSH_CYC (RFSH_CYC)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .smp     (smp),
        .rf_pend (rf_pend),
        .state   (state),
        .acc     (acc),
        .rf_ack  (rf_ack)
    );

    dseq_out_drv u_drv (
        .clk        (clk),
        .rst        (rst),
        .state      (state),
        .acc        (acc),
        .idle_row   (row_of(smp.addr)),
        .rf_row     (rf_row),
        .dram_addr  (dram_addr),
        .ras_n      (ras_n),
        .cas_n      (cas_n),
        .row_drv_en (row_drv_en),
        .col_drv_en (col_drv_en),
        .rdbuf_oe   (rdbuf_oe),
        .wrbuf_en   (wrbuf_en)
    );

    assign ras_any = !(&ras_n);

    // Row precharge: once RAS activity ends, it stays off for a clock (R9)
    assert_precharge_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_any) |=> !ras_any);

endmodule

// File: tb/dram_bank_seq_test.sv
module dram_bank_seq_test;

    localparam int R2C  = 2;
    localparam int C2C  = 1;
    localparam int PREC = 1;
    localparam int RFC  = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic        mem_rd = 1'b0, mem_wr = 1'b0, opfetch = 1'b0, refresh = 1'b0;
    logic [6:0]  dram_addr;
    logic [2:0]  ras_n;
    logic        cas_n, row_drv_en, col_drv_en, rdbuf_oe, wrbuf_en;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    dram_bank_seq #(.RAS2COL(R2C), .COL2CAS(C2C), .PRE_CYC(PREC), .RFSH_CYC(RFC)) uut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .opfetch(opfetch), .refresh(refresh), .dram_addr(dram_addr), .ras_n(ras_n),
        .cas_n(cas_n), .row_drv_en(row_drv_en), .col_drv_en(col_drv_en),
        .rdbuf_oe(rdbuf_oe), .wrbuf_en(wrbuf_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_quiet(input string req);
        chk(req, {ras_n, cas_n, rdbuf_oe, wrbuf_en, row_drv_en}, {3'b111, 1'b1, 1'b0, 1'b0, 1'b1});
    endtask

    // Full access with the timing of R2; release and precharge of R9
    task automatic do_access(input logic [15:0] a, input logic rd, input logic wr, input logic fe);
        logic [2:0] bank_ras;
        bank_ras = ~(3'b001 << a[15:14]);
        @(negedge clk);
        cpu_addr = a; mem_rd = rd; mem_wr = wr; opfetch = fe;
        for (int k = 1; k <= 3 + R2C + C2C; k++) begin
            @(negedge clk);
            if (k == 1) begin
                chk_quiet("R2 before RAS");
            end else if (k <= 1 + R2C) begin
                chk("R3 row ras", ras_n, bank_ras);
                chk("R1 row addr", {dram_addr, row_drv_en, col_drv_en, cas_n}, {a[6:0], 3'b101});
                chk("R5 row bufs", {rdbuf_oe, wrbuf_en}, {1'b0, wr});
            end else if (k <= 1 + R2C + C2C) begin
                chk("R2 col ras", ras_n, bank_ras);
                chk("R1 col addr", {dram_addr, row_drv_en, col_drv_en, cas_n}, {a[13:7], 3'b011});
                chk("R5 col bufs", {rdbuf_oe, wrbuf_en}, {1'b0, wr});
            end else begin
                chk("R2 cas", {ras_n, cas_n, col_drv_en}, {bank_ras, 1'b0, 1'b1});
                chk("R1 cas addr", dram_addr, a[13:7]);
                chk("R5 cas bufs", {rdbuf_oe, wrbuf_en}, {!wr, wr});
                chk("R10 excl", rdbuf_oe & wrbuf_en, 0);
            end
        end
        mem_rd = 0; mem_wr = 0; opfetch = 0;
        @(negedge clk);
        chk("R9 hold until seen", cas_n, 0);
        @(negedge clk);
        chk_quiet("R9 release");
        @(negedge clk);
        chk_quiet("R9 precharge");
    endtask

    task automatic do_outside(input logic [15:0] a, input logic wr);
        @(negedge clk);
        cpu_addr = a; mem_rd = !wr; mem_wr = wr;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk_quiet("R4 outside window");
        end
        mem_rd = 0; mem_wr = 0;
        @(negedge clk);
    endtask

    // Refresh timing R6/R7
    task automatic do_refresh(input logic [6:0] row, input int hold);
        @(negedge clk);
        cpu_addr = {9'h1A5, row}; refresh = 1;
        @(negedge clk);
        chk("R7 refresh not yet", ras_n, 3'b111);
        cpu_addr = 16'hFFFF;
        for (int k = 0; k < hold - 1; k++) begin
            @(negedge clk);
            chk("R6 refresh ras", {ras_n, cas_n}, {3'b000, 1'b1});
            chk("R6 refresh row", dram_addr, row);
            chk("R10 refresh bufs", {rdbuf_oe, wrbuf_en}, 0);
        end
        refresh = 0;
        @(negedge clk);
        chk("R7 refresh held", ras_n, 3'b000);
        @(negedge clk);
        chk_quiet("R9 refresh end");
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog act=running exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_quiet("R11 in reset");
        rst = 0;
        @(negedge clk);
        chk_quiet("R11 after reset");
        chk("R11 col drv", col_drv_en, 0);

        // Sweep the window: reads, writes, fetches across every bank
        for (int i = 0; i < 49152; i += 389) begin
            do_access(16'(i), 1, 0, 0);
            do_access(16'(i + 131), 0, 1, 0);
            if (i % 3 == 0) do_access(16'(i), 0, 0, 1);
        end
        do_access(16'h3FFF, 1, 0, 0);
        do_access(16'h4000, 0, 1, 0);
        do_access(16'hBFFF, 1, 0, 1);

        // Above the window
        do_outside(16'hC000, 0);
        do_outside(16'hC001, 1);
        do_outside(16'hE123, 0);
        do_outside(16'hFFFF, 1);

        // Every refresh row, alternating strobe length
        for (int r = 0; r < 128; r++) do_refresh(7'(r), (r % 2 == 0) ? 2 : 4);

        // Back-to-back access: precharge then new row (R9)
        @(negedge clk);
        cpu_addr = 16'h5123; mem_rd = 1;
        repeat (2 + R2C + C2C) @(negedge clk);
        chk("R2 b2b first cas", cas_n, 0);
        mem_rd = 0;
        @(negedge clk);
        cpu_addr = 16'h8456; mem_wr = 1;
        @(negedge clk);
        chk_quiet("R9 b2b release");
        @(negedge clk);
        chk_quiet("R9 b2b precharge");
        @(negedge clk);
        chk("R3 b2b next bank", ras_n, 3'b011);
        chk("R5 b2b write", wrbuf_en, 1);
        mem_wr = 0;
        repeat (4) @(negedge clk);

        // Refresh raised mid-access is run afterwards (R8)
        begin
            int seen;
            int rows_ok;
            seen = 0; rows_ok = 0;
            @(negedge clk);
            cpu_addr = 16'h4ABC; mem_rd = 1;
            repeat (2 + R2C + C2C) @(negedge clk);
            chk("R2 deferred cas", cas_n, 0);
            refresh = 1;
            @(negedge clk);
            refresh = 0; mem_rd = 0;
            chk("R8 access kept", {ras_n, cas_n}, {3'b101, 1'b0});
            for (int k = 0; k < 10; k++) begin
                @(negedge clk);
                if (ras_n == 3'b000) begin
                    seen++;
                    if (dram_addr == 7'h3C && cas_n) rows_ok++;
                end
            end
            chk("R8 deferred refresh cycles", seen, RFC);
            chk("R8 deferred refresh row", rows_ok, RFC);
            chk_quiet("R8 deferred end");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule